// File: doc/BRIEF.md
# Product-Term Logic Block with Sixteen Macrocells

This block is one programmable logic block of a complex PLD fabric. A bank of global routing signals enters an AND plane, where every macrocell owns a small set of product terms. Each term is a programmable AND of routing literals, and each literal is a routing signal in its true or its inverted form. A per-macrocell OR gate sums the local terms. A macrocell can also give all of its terms to the next macrocell up, or take in terms that the macrocell below has given. In this way a wide sum-of-products is built across neighbours.

The sum passes through an optional inversion and then reaches a flip-flop. The flip-flop has an optional clock enable and an optional asynchronous clear, and each of them is taken from a dedicated product term. Two independent selects decide whether the I/O-bound output and the feedback line to global routing carry the registered value or the combinational value. All programming comes from one static configuration vector, and the loading logic is outside this block. The full device tiles 32 such blocks of 16 macrocells, for 512 macrocells.

The configuration vector has one slice of `MC_W = 7 + PT_N*2*N_IN` bits for each macrocell, and slice i starts at bit `i*MC_W`. Inside a slice, bits [6:0] are the mode field. They are followed by PT_N literal masks of `2*N_IN` bits each, with mask k starting at slice bit `7 + k*2*N_IN`.

Top module: `lb_logic_block`

## Requirements
- R1: Product term k of a macrocell is the AND of every literal whose mask bit is set. Mask bit j with j < N_IN selects routing input j true. Mask bit j with j >= N_IN selects routing input j-N_IN inverted.
- R2: A product term whose mask is all zero evaluates to 0, so a macrocell with no programmed terms and no sharing produces 0.
- R3: The local sum is the OR of all local terms. Term PT_N-2 (term 3 by default) joins the sum only while the clock-enable mode is off. Term PT_N-1 (term 4) joins the sum only while the clear mode is off.
- R4: Mode bit 2 (invert) complements the sum before the register and the output selects.
- R5: Mode bit 0 (export) forces the macrocell's own sum to 0. The same bit sends its terms, together with any terms it received, to the share input of macrocell i+1.
- R6: Mode bit 1 (accept) ORs the share input into the sum. Exports chain through consecutive exporting macrocells. Macrocell 0 receives 0 on its share input, and a non-exporting macrocell passes 0 to its neighbour.
- R7: Mode bit 5 selects the register for io_out[i], and mode bit 6 selects it for fb_out[i]. The register loads the (possibly inverted) sum on each rising clock edge and holds it between edges.
- R8: With mode bit 3 set, the register loads only on edges where term PT_N-2 is 1, and it holds its value otherwise.
- R9: With mode bit 4 set, term PT_N-1 clears the register at once, without waiting for a clock edge.
- R10: A synchronous active-high rst clears every macrocell register at the next clock edge.
- R11: With mode bits 5 and 6 both clear, io_out[i] and fb_out[i] both carry the combinational result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the macrocell registers |
| rst | input | 1 | Synchronous active-high reset of the registers |
| cfg | input | N_MC*MC_W | Static programming vector |
| rt_in | input | N_IN | Global routing signals into the AND plane |
| io_out | output | N_MC | Per-macrocell result toward the I/O cells |
| fb_out | output | N_MC | Per-macrocell result back to global routing |

## Verification
The bench builds the block with N_MC = 4, N_IN = 6 and PT_N = 5. With these values the whole space of routing inputs can be swept in 64 vectors for every product-term function. Four macrocells are enough for a three-deep sharing chain, plus one macrocell whose neighbour does not export. The default term count keeps the clock-enable and clear terms at positions 3 and 4, so those modes are exercised at their normal slots.

// File: rtl/lb_pkg.sv
package lb_pkg;
  // Per-macrocell mode field; export_pts is bit 0, fb_reg is bit 6.
  typedef struct packed {
    logic fb_reg;
    logic io_reg;
    logic clr_en;
    logic ce_en;
    logic inv;
    logic use_share;
    logic export_pts;
  } mc_mode_t;

  localparam int MODE_W = $bits(mc_mode_t);
endpackage

// File: rtl/lb_and_plane.sv
module lb_and_plane #(
  parameter int N_IN = 36,
  parameter int PT_N = 5,
  localparam int LIT_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]       rt_in,
  input  logic [PT_N*LIT_W-1:0] masks,
  output logic [PT_N-1:0]       pt
);
  logic [LIT_W-1:0] lits;
  assign lits = {~rt_in, rt_in};

  for (genvar k = 0; k < PT_N; k++) begin : g_pt
    logic [LIT_W-1:0] m;
    assign m = masks[k*LIT_W +: LIT_W];
    // an empty mask is an unprogrammed term and yields 0
    assign pt[k] = (|m) & (&(lits | ~m));
  end
endmodule

// File: rtl/lb_macrocell.sv
module lb_macrocell #(
  parameter int PT_N = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PT_N-1:0]   pt,
  input  lb_pkg::mc_mode_t  mode,
  input  logic              share_in,
  output logic              share_out,
  output logic              io_o,
  output logic              fb_o
);
  localparam int CE_IDX  = PT_N - 2;
  localparam int CLR_IDX = PT_N - 1;

  logic [PT_N-1:0] sum_mask;
  logic            pool, comb, ce, aclr, q;

  always_comb begin
    sum_mask          = '1;
    sum_mask[CE_IDX]  = ~mode.ce_en;
    sum_mask[CLR_IDX] = ~mode.clr_en;
  end

  assign pool      = (|(pt & sum_mask)) | (mode.use_share & share_in);
  assign share_out = mode.export_pts & pool;
  assign comb      = (~mode.export_pts & pool) ^ mode.inv;
  assign ce        = mode.ce_en ? pt[CE_IDX] : 1'b1;
  assign aclr      = mode.clr_en & pt[CLR_IDX];

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)     q <= 1'b0;
    else if (rst) q <= 1'b0;
    else if (ce)  q <= comb;
  end

  assign io_o = mode.io_reg ? q : comb;
  assign fb_o = mode.fb_reg ? q : comb;
endmodule

// File: rtl/lb_logic_block.sv
module lb_logic_block #(
  parameter int N_MC = 16,
  parameter int N_IN = 36,
  parameter int PT_N = 5,
  localparam int LIT_W = 2 * N_IN,
  localparam int MC_W  = lb_pkg::MODE_W + PT_N * LIT_W,
  localparam int CFG_W = N_MC * MC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic [N_IN-1:0]  rt_in,
  output logic [N_MC-1:0]  io_out,
  output logic [N_MC-1:0]  fb_out
);
  logic [N_MC:0] share;
  assign share[0] = 1'b0;

  for (genvar i = 0; i < N_MC; i++) begin : g_mc
    logic [MC_W-1:0]  slice;
    logic [PT_N-1:0]  pt;
    lb_pkg::mc_mode_t mode;

    assign slice = cfg[i*MC_W +: MC_W];
    assign mode  = lb_pkg::mc_mode_t'(slice[lb_pkg::MODE_W-1:0]);

    lb_and_plane #(.N_IN(N_IN), .PT_N(PT_N)) u_and (
      .rt_in (rt_in),
      .masks (slice[MC_W-1:lb_pkg::MODE_W]),
      .pt    (pt)
    );

    lb_macrocell #(.PT_N(PT_N)) u_mc (
      .clk       (clk),
      .rst       (rst),
      .pt        (pt),
      .mode      (mode),
      .share_in  (share[i]),
      .share_out (share[i+1]),
      .io_o      (io_out[i]),
      .fb_o      (fb_out[i])
    );
  end
endmodule

// File: rtl/lb_logic_block_chk.sv
module lb_logic_block_chk #(
  parameter int N_MC = 16,
  parameter int N_IN = 36,
  parameter int PT_N = 5,
  localparam int LIT_W = 2 * N_IN,
  localparam int MC_W  = lb_pkg::MODE_W + PT_N * LIT_W,
  localparam int CFG_W = N_MC * MC_W
) (
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] cfg,
  input logic [N_MC-1:0]  io_out,
  input logic [N_MC-1:0]  fb_out
);
  for (genvar i = 0; i < N_MC; i++) begin : g_chk
    lb_pkg::mc_mode_t md;
    logic [LIT_W-1:0] ce_mask;
    assign md      = lb_pkg::mc_mode_t'(cfg[i*MC_W +: lb_pkg::MODE_W]);
    assign ce_mask = cfg[i*MC_W + lb_pkg::MODE_W + (PT_N-2)*LIT_W +: LIT_W];

    // R10
    reg_cleared_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && md.io_reg) |-> (io_out[i] == 1'b0));

    // R11
    comb_match_chk: assert property (@(posedge clk) disable iff (rst)
      (!md.io_reg && !md.fb_reg) |-> (io_out[i] == fb_out[i]));

    // R5
    export_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (md.export_pts && !md.inv && !md.fb_reg) |-> (fb_out[i] == 1'b0));

    // R8
    ce_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst && md.ce_en && (ce_mask == '0) && !md.clr_en && md.io_reg)
      |=> (!$stable(cfg) || (io_out[i] == $past(io_out[i]))));
  end
endmodule

bind lb_logic_block lb_logic_block_chk #(.N_MC(N_MC), .N_IN(N_IN), .PT_N(PT_N)) u_chk (
  .clk(clk), .rst(rst), .cfg(cfg), .io_out(io_out), .fb_out(fb_out)
);

// File: tb/sim_lb_logic_block.sv
`timescale 1ns/100ps
module sim_lb_logic_block;
  localparam int N_MC  = 4;
  localparam int N_IN  = 6;
  localparam int PT_N  = 5;
  localparam int LIT_W = 2 * N_IN;
  localparam int MODE_W = 7;
  localparam int MC_W  = MODE_W + PT_N * LIT_W;
  localparam int CFG_W = N_MC * MC_W;
  // mode bit positions
  localparam int B_EXP = 0, B_SHR = 1, B_INV = 2, B_CE = 3, B_CLR = 4, B_IOR = 5, B_FBR = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CFG_W-1:0] cfg = '0;
  logic [N_IN-1:0]  rt_in = '0;
  logic [N_MC-1:0]  io_out, fb_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lb_logic_block #(.N_MC(N_MC), .N_IN(N_IN), .PT_N(PT_N)) u0 (
    .clk(clk), .rst(rst), .cfg(cfg), .rt_in(rt_in), .io_out(io_out), .fb_out(fb_out)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic add_lit(int mc, int k, int lit);
    cfg[mc*MC_W + MODE_W + k*LIT_W + lit] = 1'b1;
  endtask

  task automatic set_mode(int mc, int b);
    cfg[mc*MC_W + b] = 1'b1;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
  endtask

  task automatic t_reset_state();
    cfg = '0; rt_in = '1;
    for (int i = 0; i < N_MC; i++) set_mode(i, B_IOR);
    do_reset(); #1;
    for (int i = 0; i < N_MC; i++) begin
      chk("R10 io after reset", io_out[i], 1'b0);
      chk("R2 fb unprogrammed", fb_out[i], 1'b0);
    end
  endtask

  task automatic t_and_or();
    cfg = '0;
    add_lit(0, 0, 0); add_lit(0, 0, N_IN + 1); add_lit(0, 1, 2);
    add_lit(3, 3, 3); add_lit(3, 4, 4);
    for (int v = 0; v < 64; v++) begin
      rt_in = v[N_IN-1:0]; #1;
      chk("R1 sop io", io_out[0], (v[0] & ~v[1]) | v[2]);
      chk("R11 sop fb", fb_out[0], (v[0] & ~v[1]) | v[2]);
      chk("R2 empty mc", io_out[1], 1'b0);
      chk("R3 terms 3,4 in sum", io_out[3], v[3] | v[4]);
    end
  endtask

  task automatic t_invert();
    cfg = '0;
    add_lit(1, 0, 3); set_mode(1, B_INV);
    for (int v = 0; v < 64; v++) begin
      rt_in = v[N_IN-1:0]; #1;
      chk("R4 invert", io_out[1], ~v[3]);
    end
  endtask

  task automatic t_share();
    cfg = '0;
    add_lit(0, 0, 0); set_mode(0, B_EXP);
    add_lit(1, 0, 1); set_mode(1, B_EXP); set_mode(1, B_SHR);
    add_lit(2, 0, 2); set_mode(2, B_SHR);
    add_lit(3, 0, 5); set_mode(3, B_SHR);
    for (int v = 0; v < 64; v++) begin
      rt_in = v[N_IN-1:0]; #1;
      chk("R5 exporter mc0 quiet", fb_out[0], 1'b0);
      chk("R5 exporter mc1 quiet", io_out[1], 1'b0);
      chk("R6 chained sum", io_out[2], v[0] | v[1] | v[2]);
      chk("R6 no share from non-exporter", io_out[3], v[5]);
    end
  endtask

  task automatic t_register();
    cfg = '0; rt_in = '0;
    add_lit(0, 0, 0); set_mode(0, B_IOR);
    do_reset();
    rt_in[0] = 1'b1; #1;
    chk("R7 reg before edge", io_out[0], 1'b0);
    chk("R7 fb comb", fb_out[0], 1'b1);
    step();
    chk("R7 reg after edge", io_out[0], 1'b1);
    rt_in[0] = 1'b0; #1;
    chk("R7 reg holds", io_out[0], 1'b1);
    chk("R7 fb follows", fb_out[0], 1'b0);
    step();
    chk("R7 reg reloads", io_out[0], 1'b0);
  endtask

  task automatic t_clock_enable();
    cfg = '0; rt_in = '0;
    add_lit(1, 0, 0); add_lit(1, 3, 5); set_mode(1, B_IOR); set_mode(1, B_CE);
    do_reset();
    rt_in[0] = 1'b1; step();
    chk("R8 held when ce low", io_out[1], 1'b0);
    rt_in[5] = 1'b1; step();
    chk("R8 loads when ce high", io_out[1], 1'b1);
    rt_in[0] = 1'b0; #1;
    chk("R3 ce term not in sum", fb_out[1], 1'b0);
    rt_in[5] = 1'b0; step();
    chk("R8 holds one", io_out[1], 1'b1);
  endtask

  task automatic t_async_clear();
    cfg = '0; rt_in = '0;
    add_lit(2, 0, 0); add_lit(2, 4, 4); set_mode(2, B_IOR); set_mode(2, B_CLR);
    do_reset();
    rt_in[0] = 1'b1; step();
    chk("R9 set before clear", io_out[2], 1'b1);
    rt_in[4] = 1'b1; #1;
    chk("R9 cleared without edge", io_out[2], 1'b0);
    rt_in[0] = 1'b0; #1;
    chk("R3 clear term not in sum", fb_out[2], 1'b0);
    rt_in[4] = 1'b0; rt_in[0] = 1'b1; step();
    chk("R9 reloads after clear", io_out[2], 1'b1);
  endtask

  task automatic t_sync_reset();
    cfg = '0; rt_in = '0;
    add_lit(3, 0, 0); set_mode(3, B_IOR); set_mode(3, B_FBR);
    do_reset();
    rt_in[0] = 1'b1; step();
    chk("R7 fb registered", fb_out[3], 1'b1);
    rst = 1'b1; #1;
    chk("R10 no clear before edge", io_out[3], 1'b1);
    step();
    chk("R10 cleared at edge", io_out[3], 1'b0);
    chk("R10 fb cleared", fb_out[3], 1'b0);
    rst = 1'b0; step();
    chk("R10 resumes", io_out[3], 1'b1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset_state();
    t_and_or();
    t_invert();
    t_share();
    t_register();
    t_clock_enable();
    t_async_clear();
    t_sync_reset();
    done = 1'b1;
    summary();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end
endmodule